// File: doc/BRIEF.md
# Operand Memoization Lookup Unit

This unit sits next to a floating-point functional unit and reuses results it has already produced. It holds a small table. Each row pairs a ternary operand pattern with a precomputed result. Before a compute job starts, a host port loads the table. During the job, every operation issued to the functional unit is also searched in the table.

When an operation hits, the stored result is delivered and the row is treated as correct, even if the functional unit signalled a timing error for that same operation. When it misses, the functional unit's own result is forwarded. If that result carries the error flag, a one-cycle recovery request is raised.

One instance serves one operation type. A two-operand operation such as add or multiply keys on both operands. A one-operand operation such as square root keys on the first operand alone. Running counters of lookups and hits let the hit rate be observed.

Top module: `memo_lookup_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every table row becomes invalid, and `out_valid`, `out_hit`, `recover_req`, `lookup_cnt` and `hit_cnt` read zero after that edge. A lookup issued after reset, with no rows written, misses.
- R2: Each key bit is ternary. Where the programmed `prog_care` bit is 1, the operand bit must equal the `prog_key` bit. Where it is 0, the bit matches either value. A row is a hit only when it is valid and every bit matches.
- R3: An operation presented with `op_valid` high at rising edge N yields `out_valid` high for exactly one cycle, after edge N+1. The functional unit's `fu_res`/`fu_err` for that operation are sampled at edge N+1.
- R4: On a hit, `out_hit` is 1, `out_res` equals the stored result, and `recover_req` is 0, whatever the value of `fu_err`.
- R5: On a miss, `out_hit` is 0 and `out_res` equals `fu_res`. `recover_req` is 1 in the result cycle exactly when `fu_err` was 1, and is 0 in every cycle without a result.
- R6: When several valid rows match, the result of the row with the lowest index is returned.
- R7: A row becomes valid only when it is written. A write at edge N is seen by lookups sampled at edge N+1 or later.
- R8: A write is ignored when `op_valid` is high at its edge, or when a lookup sampled at the previous edge is still in its second stage.
- R9: In two-operand mode the search key is `{op_a, op_b}`, with `op_a` in the upper half, so both operands and their order take part. In one-operand mode the key is `op_a`, and `op_b` is ignored.
- R10: `lookup_cnt` rises by one with every result cycle, and `hit_cnt` rises by one with every result cycle that is a hit. Both change together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Table write strobe |
| prog_idx | input | IDXW | Row index to write |
| prog_key | input | KEYW | Key bits of the row |
| prog_care | input | KEYW | 1 = compare this bit, 0 = don't care |
| prog_res | input | RESW | Stored result of the row |
| op_valid | input | 1 | An operation is issued this cycle |
| op_a | input | OPW | First operand |
| op_b | input | OPW | Second operand (two-operand mode) |
| fu_res | input | RESW | Functional unit result, one cycle after issue |
| fu_err | input | 1 | Functional unit timing-error flag, aligned with fu_res |
| out_valid | output | 1 | Result cycle |
| out_res | output | RESW | Delivered result |
| out_hit | output | 1 | Result came from the table |
| recover_req | output | 1 | Miss with timing error: redo the operation |
| lookup_cnt | output | CNTW | Completed lookups |
| hit_cnt | output | CNTW | Completed hits |

## Verification
The latency and recovery properties assume two things. First, `op_valid` stays low while reset is held. Second, the functional-unit result and its error flag for each issued operation arrive exactly one cycle after the issue. The bench meets both with one driver. That driver holds `op_valid` low through reset and carries each operation's result and error forward into the following cycle. In cycles with no operation in stage two, it fills `fu_res`/`fu_err` with random values, so the bench can show that they are ignored. The counter properties assume reset is held for at least two edges, which the bench does.

// File: rtl/memo_pkg.sv
package memo_pkg;

  // Which operands form the search key.
  typedef enum logic {
    KEY_ONE_OPERAND = 1'b0,
    KEY_TWO_OPERAND = 1'b1
  } key_mode_e;

endpackage

// File: rtl/memo_tcam_array.sv
// Ternary pattern storage with one comparator per row.
// Each stored bit is held as a 2-bit code: accept-one and accept-zero.
// Don't-care sets both; a cared bit sets exactly one.
module memo_tcam_array #(
  parameter int ENTRIES = 32,
  parameter int KEYW    = 64,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [KEYW-1:0]    wr_key,
  input  logic [KEYW-1:0]    wr_care,
  input  logic [KEYW-1:0]    probe,
  output logic [ENTRIES-1:0] match
);

  logic [KEYW-1:0]    acc1_mem [ENTRIES];
  logic [KEYW-1:0]    acc0_mem [ENTRIES];
  logic [ENTRIES-1:0] row_valid_q;

  // Pattern cells carry no reset so that they map onto plain storage.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      acc1_mem[wr_idx] <= ~wr_care | wr_key;
      acc0_mem[wr_idx] <= ~wr_care | ~wr_key;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_valid_q <= '0;
    end else if (wr_en) begin
      row_valid_q[wr_idx] <= 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    logic [KEYW-1:0] bit_ok;
    assign bit_ok   = (probe & acc1_mem[g]) | (~probe & acc0_mem[g]);
    assign match[g] = row_valid_q[g] & (&bit_ok);
  end

endmodule

// File: rtl/memo_first_match.sv
// Lowest-index-wins encoder over the row match vector.
module memo_first_match #(
  parameter int ENTRIES = 32,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match,
  output logic               any,
  output logic [IDXW-1:0]    idx
);

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDXW'(i);
    end
  end

  assign any = |match;

endmodule

// File: rtl/memo_result_store.sv
// Result memory: one write port, one registered read port.
module memo_result_store #(
  parameter int ENTRIES = 32,
  parameter int RESW    = 32,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [RESW-1:0] wr_data,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_idx,
  output logic [RESW-1:0] rd_data
);

  logic [RESW-1:0] res_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) res_mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= res_mem[rd_idx];
  end

endmodule

// File: rtl/memo_lookup_unit.sv
// Two-stage memoization lookup beside a floating-point unit.
// Stage one: ternary search and priority pick. Stage two: result read,
// merge with the functional unit outcome, recovery decision, counters.
module memo_lookup_unit
  import memo_pkg::*;
#(
  parameter key_mode_e KEY_MODE = KEY_TWO_OPERAND,
  parameter int ENTRIES = 32,
  parameter int OPW     = 32,
  parameter int RESW    = 32,
  parameter int CNTW    = 32,
  localparam int NOPS   = (KEY_MODE == KEY_TWO_OPERAND) ? 2 : 1,
  localparam int KEYW   = OPW * NOPS,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_we,
  input  logic [IDXW-1:0] prog_idx,
  input  logic [KEYW-1:0] prog_key,
  input  logic [KEYW-1:0] prog_care,
  input  logic [RESW-1:0] prog_res,
  input  logic            op_valid,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  input  logic [RESW-1:0] fu_res,
  input  logic            fu_err,
  output logic            out_valid,
  output logic [RESW-1:0] out_res,
  output logic            out_hit,
  output logic            recover_req,
  output logic [CNTW-1:0] lookup_cnt,
  output logic [CNTW-1:0] hit_cnt
);

  logic [KEYW-1:0]    probe;
  logic [ENTRIES-1:0] match;
  logic               any_hit;
  logic [IDXW-1:0]    hit_idx;
  logic               wr_ok;

  logic               s1_valid_q;
  logic               s1_hit_q;
  logic [IDXW-1:0]    s1_idx_q;

  logic               s2_valid_q;
  logic               s2_hit_q;
  logic [RESW-1:0]    s2_fu_q;
  logic               s2_rec_q;
  logic [RESW-1:0]    stored_res;
  logic [CNTW-1:0]    lookup_cnt_q;
  logic [CNTW-1:0]    hit_cnt_q;

  // Key formation picked by the operation type.
  if (KEY_MODE == KEY_TWO_OPERAND) begin : g_key_two
    assign probe = {op_a, op_b};
  end else begin : g_key_one
    assign probe = op_a;
  end

  // The table is frozen while a lookup occupies either stage.
  assign wr_ok = prog_we & ~op_valid & ~s1_valid_q;

  memo_tcam_array #(
    .ENTRIES (ENTRIES),
    .KEYW    (KEYW)
  ) i_tcam (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok),
    .wr_idx  (prog_idx),
    .wr_key  (prog_key),
    .wr_care (prog_care),
    .probe   (probe),
    .match   (match)
  );

  memo_first_match #(
    .ENTRIES (ENTRIES)
  ) i_first (
    .match (match),
    .any   (any_hit),
    .idx   (hit_idx)
  );

  // Stage one registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid_q <= 1'b0;
      s1_hit_q   <= 1'b0;
      s1_idx_q   <= '0;
    end else begin
      s1_valid_q <= op_valid;
      s1_hit_q   <= op_valid & any_hit;
      s1_idx_q   <= hit_idx;
    end
  end

  memo_result_store #(
    .ENTRIES (ENTRIES),
    .RESW    (RESW)
  ) i_store (
    .clk     (clk),
    .wr_en   (wr_ok),
    .wr_idx  (prog_idx),
    .wr_data (prog_res),
    .rd_en   (s1_valid_q & s1_hit_q),
    .rd_idx  (s1_idx_q),
    .rd_data (stored_res)
  );

  // Stage two registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid_q   <= 1'b0;
      s2_hit_q     <= 1'b0;
      s2_rec_q     <= 1'b0;
      s2_fu_q      <= '0;
      lookup_cnt_q <= '0;
      hit_cnt_q    <= '0;
    end else begin
      s2_valid_q <= s1_valid_q;
      s2_hit_q   <= s1_valid_q & s1_hit_q;
      s2_rec_q   <= s1_valid_q & ~s1_hit_q & fu_err;
      s2_fu_q    <= fu_res;
      if (s1_valid_q) lookup_cnt_q <= lookup_cnt_q + CNTW'(1);
      if (s1_valid_q & s1_hit_q) hit_cnt_q <= hit_cnt_q + CNTW'(1);
    end
  end

  assign out_valid   = s2_valid_q;
  assign out_hit     = s2_hit_q;
  assign out_res     = s2_hit_q ? stored_res : s2_fu_q;
  assign recover_req = s2_rec_q;
  assign lookup_cnt  = lookup_cnt_q;
  assign hit_cnt     = hit_cnt_q;

endmodule

// File: rtl/memo_lookup_checks.sv
// Port-level properties of the memoization lookup unit.
module memo_lookup_checks #(
  parameter int RESW = 32,
  parameter int CNTW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [RESW-1:0] fu_res,
  input logic            fu_err,
  input logic            out_valid,
  input logic [RESW-1:0] out_res,
  input logic            out_hit,
  input logic            recover_req,
  input logic [CNTW-1:0] lookup_cnt,
  input logic [CNTW-1:0] hit_cnt
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_hit && !recover_req && lookup_cnt == '0 && hit_cnt == '0));

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> ##1 out_valid);

  p_no_orphan_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(op_valid, 2));

  p_hit_no_recover_r4: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> (out_valid && !recover_req));

  p_recover_on_miss_r5: assert property (@(posedge clk) disable iff (rst)
    recover_req |-> (out_valid && !out_hit && $past(fu_err)));

  p_miss_forward_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (out_res == $past(fu_res)));

  p_lookup_step_r10: assert property (@(posedge clk) disable iff (rst)
    lookup_cnt == $past(lookup_cnt) + CNTW'(out_valid));

  p_hit_step_r10: assert property (@(posedge clk) disable iff (rst)
    hit_cnt == $past(hit_cnt) + CNTW'(out_hit));

endmodule

bind memo_lookup_unit memo_lookup_checks #(
  .RESW (RESW),
  .CNTW (CNTW)
) u_checks (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .fu_res      (fu_res),
  .fu_err      (fu_err),
  .out_valid   (out_valid),
  .out_res     (out_res),
  .out_hit     (out_hit),
  .recover_req (recover_req),
  .lookup_cnt  (lookup_cnt),
  .hit_cnt     (hit_cnt)
);

// File: tb/test_memo_lookup_unit.sv
module test_memo_lookup_unit;

  localparam int ENT  = 32;
  localparam int OPW  = 32;
  localparam int RESW = 32;
  localparam int KEYW = 64;
  localparam int CNTW = 32;
  localparam int IDXW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            prog_we = 1'b0;
  logic [IDXW-1:0] prog_idx = '0;
  logic [KEYW-1:0] prog_key = '0;
  logic [KEYW-1:0] prog_care = '0;
  logic [RESW-1:0] prog_res = '0;
  logic            op_valid = 1'b0;
  logic [OPW-1:0]  op_a = '0;
  logic [OPW-1:0]  op_b = '0;
  logic [RESW-1:0] fu_res = '0;
  logic            fu_err = 1'b0;
  logic            out_valid;
  logic [RESW-1:0] out_res;
  logic            out_hit;
  logic            recover_req;
  logic [CNTW-1:0] lookup_cnt;
  logic [CNTW-1:0] hit_cnt;

  always #2 clk = ~clk;

  memo_lookup_unit i_memo_lookup_unit (
    .clk(clk), .rst(rst),
    .prog_we(prog_we), .prog_idx(prog_idx), .prog_key(prog_key),
    .prog_care(prog_care), .prog_res(prog_res),
    .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .fu_res(fu_res), .fu_err(fu_err),
    .out_valid(out_valid), .out_res(out_res), .out_hit(out_hit),
    .recover_req(recover_req), .lookup_cnt(lookup_cnt), .hit_cnt(hit_cnt)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural reference state.
  logic [KEYW-1:0] mk [ENT];
  logic [KEYW-1:0] mc [ENT];
  logic [RESW-1:0] mr [ENT];
  bit              mv [ENT];
  bit              m_s1v, m_s1h;
  logic [RESW-1:0] m_s1r;
  bit              m_ov, m_oh, m_orec;
  logic [RESW-1:0] m_ores;
  int              m_lc, m_hc;
  logic [RESW-1:0] cur_fr, car_fr;
  bit              cur_fe, car_fe;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit nh;
    logic [RESW-1:0] nr;
    bit wok;
    if (rst) begin
      for (int i = 0; i < ENT; i++) mv[i] = 0;
      m_s1v = 0; m_s1h = 0; m_ov = 0; m_oh = 0; m_orec = 0;
      m_lc = 0; m_hc = 0;
      return;
    end
    m_ov   = m_s1v;
    m_oh   = m_s1v && m_s1h;
    m_ores = m_oh ? m_s1r : fu_res;
    m_orec = m_s1v && !m_s1h && fu_err;
    if (m_ov) m_lc++;
    if (m_oh) m_hc++;
    nh = 0; nr = '0;
    if (op_valid) begin
      for (int i = ENT - 1; i >= 0; i--) begin
        if (mv[i] && ((({op_a, op_b} ^ mk[i]) & mc[i]) == '0)) begin
          nh = 1; nr = mr[i];
        end
      end
    end
    wok = prog_we && !op_valid && !m_s1v;
    m_s1v = op_valid; m_s1h = nh; m_s1r = nr;
    if (wok) begin
      mk[prog_idx] = prog_key; mc[prog_idx] = prog_care;
      mr[prog_idx] = prog_res; mv[prog_idx] = 1;
    end
  endtask

  task automatic compare();
    chk("R3 out_valid", 64'(out_valid), 64'(m_ov));
    if (m_ov) begin
      chk("R2 out_hit", 64'(out_hit), 64'(m_oh));
      chk(m_oh ? "R4 out_res" : "R5 out_res", 64'(out_res), 64'(m_ores));
      chk("R5 recover_req", 64'(recover_req), 64'(m_orec));
    end else begin
      chk("R5 recover_req idle", 64'(recover_req), 64'(0));
    end
    chk("R10 lookup_cnt", 64'(lookup_cnt), 64'(m_lc));
    chk("R10 hit_cnt", 64'(hit_cnt), 64'(m_hc));
  endtask

  // One clock: functional unit result of the previous issue goes out now.
  task automatic step();
    fu_res = car_fr;
    fu_err = car_fe;
    model_edge();
    if (op_valid) begin
      car_fr = cur_fr; car_fe = cur_fe;
    end else begin
      car_fr = $urandom; car_fe = 1'($urandom % 2);
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic lookup(logic [OPW-1:0] a, logic [OPW-1:0] b,
                        logic [RESW-1:0] fr, bit fe);
    op_valid = 1; op_a = a; op_b = b; cur_fr = fr; cur_fe = fe;
    step();
    op_valid = 0;
    step();
  endtask

  task automatic prog(int idx, logic [KEYW-1:0] key, logic [KEYW-1:0] care,
                      logic [RESW-1:0] res);
    prog_we = 1; prog_idx = IDXW'(idx); prog_key = key;
    prog_care = care; prog_res = res;
    step();
    prog_we = 0;
  endtask

  localparam logic [31:0] A1 = 32'h3F80_0000, B1 = 32'h4000_0000;
  localparam logic [31:0] A2 = 32'h4120_0000, B2 = 32'h4130_0000;
  localparam logic [31:0] RES5  = 32'h4040_0000;
  localparam logic [31:0] RES3  = 32'h41A8_0000;
  localparam logic [31:0] RES10 = 32'hC0DE_0010;
  localparam logic [31:0] RES20 = 32'h1234_5678;
  localparam logic [63:0] ALL   = {64{1'b1}};

  initial begin
    car_fr = '0; car_fe = 0; cur_fr = '0; cur_fe = 0;
    m_s1r = '0; m_ores = '0;
    @(negedge clk);
    repeat (4) step();
    chk("R1 out_valid after reset", 64'(out_valid), 64'(0));
    chk("R1 lookup_cnt after reset", 64'(lookup_cnt), 64'(0));
    chk("R1 hit_cnt after reset", 64'(hit_cnt), 64'(0));
    rst = 0;
    step();

    // Empty table: miss, error forwarded as recovery.
    lookup(A1, B1, 32'hAAAA_0001, 1);
    chk("R1 empty table miss", 64'(out_hit), 64'(0));
    chk("R7 unwritten row misses", 64'(out_res), 64'(32'hAAAA_0001));
    chk("R5 recovery on miss with error", 64'(recover_req), 64'(1));

    prog(5, {A1, B1}, ALL, RES5);
    lookup(A1, B1, 32'hBBBB_0002, 1);
    chk("R7 written row hits", 64'(out_hit), 64'(1));
    chk("R4 stored result despite error", 64'(out_res), 64'(RES5));
    chk("R4 no recovery on hit", 64'(recover_req), 64'(0));

    lookup(A1, B1 ^ 32'h1, 32'hCCCC_0003, 0);
    chk("R9 op_b part of key", 64'(out_hit), 64'(0));
    chk("R5 miss no error no recovery", 64'(recover_req), 64'(0));
    lookup(B1, A1, 32'hCCCC_0004, 0);
    chk("R9 operand order matters", 64'(out_hit), 64'(0));

    // Overlapping ternary rows.
    prog(10, {A2, B2}, {32'hFFFF_FFFF, 32'hFF00_0000}, RES10);
    prog(3,  {A2, B2}, {32'hFFFF_FFFF, 32'hFFFF_0000}, RES3);
    lookup(A2, 32'h4130_1234, 32'h0, 1);
    chk("R6 lowest index wins", 64'(out_res), 64'(RES3));
    lookup(A2, 32'h4131_0000, 32'h0, 1);
    chk("R2 don't-care bits match", 64'(out_res), 64'(RES10));
    lookup(A2, 32'h5130_0000, 32'hDDDD_0005, 1);
    chk("R2 cared bit mismatch misses", 64'(out_hit), 64'(0));
    chk("R5 forwarded on miss", 64'(out_res), 64'(32'hDDDD_0005));

    // Writes during a lookup are dropped.
    op_valid = 1; op_a = 32'h1; op_b = 32'h2; cur_fr = 32'h7; cur_fe = 0;
    prog_we = 1; prog_idx = 5'd20; prog_key = {32'h11, 32'h22};
    prog_care = ALL; prog_res = RES20;
    step();
    op_valid = 0; prog_idx = 5'd21; prog_key = {32'h33, 32'h44};
    step();
    prog_we = 0;
    step();
    lookup(32'h11, 32'h22, 32'h9, 0);
    chk("R8 write with op_valid ignored", 64'(out_hit), 64'(0));
    lookup(32'h33, 32'h44, 32'h9, 0);
    chk("R8 write during stage two ignored", 64'(out_hit), 64'(0));
    prog(20, {32'h11, 32'h22}, ALL, RES20);
    lookup(32'h11, 32'h22, 32'h9, 1);
    chk("R7 idle write takes effect", 64'(out_res), 64'(RES20));

    // Back-to-back lookups.
    op_valid = 1; op_a = A1; op_b = B1; cur_fr = 32'h1; cur_fe = 1; step();
    op_a = 32'h5; op_b = 32'h6; cur_fr = 32'hE0E0_0006; cur_fe = 1; step();
    chk("R3 first of pair", 64'(out_res), 64'(RES5));
    op_valid = 0; step();
    chk("R3 second of pair forwarded", 64'(out_res), 64'(32'hE0E0_0006));
    chk("R5 second of pair recovery", 64'(recover_req), 64'(1));

    // Mixed random traffic.
    for (int c = 0; c < 600; c++) begin
      int sel;
      op_valid = ($urandom % 4) != 0;
      sel = $urandom % 4;
      case (sel)
        0: begin op_a = A1; op_b = B1; end
        1: begin op_a = A2; op_b = {16'h4130, 16'($urandom)}; end
        2: begin op_a = A2; op_b = {8'h41, 24'($urandom)}; end
        default: begin op_a = $urandom; op_b = $urandom; end
      endcase
      cur_fr = $urandom; cur_fe = 1'($urandom % 2);
      prog_we = ($urandom % 6) == 0;
      prog_idx = IDXW'(24 + ($urandom % 8));
      prog_key = {A1, B1 ^ 32'($urandom % 4)};
      prog_care = ALL;
      prog_res = $urandom;
      step();
    end
    op_valid = 0; prog_we = 0;
    step(); step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule